// File: doc/BRIEF.md
# Banked Register File Access Unit

This unit sits between the execute stage of a small 8-bit core and its data memory. Each instruction names a 5-bit register location. The unit turns that location, together with a file-select pointer, into one of four banks of 32 locations. Location 0 of the instruction space holds no storage. Naming it makes the unit use the full pointer as the address, which gives indirect access. The lower half of every bank folds back onto bank 0, so the status register, the pointer and the eight low general-purpose bytes can be reached whatever bank is selected. The upper half of each bank is private storage for that bank.

Reads are combinational from a read location. Writes take effect on the clock edge from a separate write location, write data and write enable. The status register combines software-writable bits, two read-only condition bits and three ALU flags. The ALU flags come in with a valid strobe. When the strobe is high, the flags win over any register write to the status register in the same cycle.

Top module: `dmem_bank_access`

## Requirements
- R1: While reset is applied, and after it is released, the status output reads 0x18 and the pointer output reads 0x00.
- R2: An upper-half location (0x10 to 0x1F) is separate storage in each of the four banks. The bank comes from pointer bits 6:5 for direct accesses as well as indirect ones.
- R3: Offsets 0x00 to 0x0F of every bank reach the same resource as in bank 0. This covers general-purpose bytes 0x08 to 0x0F, the status register at offset 0x03 and the pointer at offset 0x04, whether reached directly or indirectly.
- R4: An access to location 0x00 uses all seven pointer bits as the address, for both reads and writes.
- R5: When the pointer's low five bits are zero, an indirect read returns 0x00. An indirect write in that case changes no register.
- R6: Offsets 0x01, 0x02 and 0x05 to 0x07 read 0x00, and writes to them change no storage.
- R7: Status bits 4 and 3 always read 1 and status bit 6 always reads 0, whatever is written.
- R8: A status write with the flag strobe low stores write-data bits 7, 5 and 2:0 (Z at bit 2, DC at bit 1, C at bit 0).
- R9: With the flag strobe high, status bits 2:0 take the ALU flag inputs {Z, DC, C}. A status write in the same cycle still updates bits 7 and 5.
- R10: A pointer write stores data bits 6:0. Pointer bit 7 always reads 0.
- R11: The read data shows the register state before a same-cycle write. A write becomes visible in the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_loc | input | 5 | Read location from the instruction |
| wr_loc | input | 5 | Write location from the instruction |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write enable |
| alu_flags | input | 3 | ALU flags {Z, DC, C}; DC is carry out of bit 3, and C and DC are inverted borrows for subtraction |
| flags_vld | input | 1 | ALU flags are valid this cycle |
| rd_data | output | 8 | Read data for rd_loc |
| status_q | output | 8 | Status register |
| ptr_q | output | 8 | File-select pointer |

## Verification
The assertions take for granted that write data and ALU flags are known whenever their enables are high. They also assume the core never expects a general-purpose byte to hold a value before something has written it, because that storage has no reset. The stimulus drives every input at the falling edge and keeps all enables low while the internal reset is still held. It reads back only locations that the same run wrote earlier. Bank selection is always changed through a pointer write in a cycle of its own, so each checked read has one predictable target.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_NULL,
    TGT_STAT,
    TGT_PTR,
    TGT_GPR
  } tgt_e;

  localparam int unsigned STAT_LOC = 3;
  localparam int unsigned PTR_LOC  = 4;

  localparam int unsigned SB_WAKE = 7;
  localparam int unsigned SB_PAGE = 5;
  localparam int unsigned SB_TO   = 4;
  localparam int unsigned SB_PD   = 3;

endpackage

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
  import dmem_pkg::*;
#(
  parameter int unsigned LOC_W    = 5,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned GPR_BASE = 8,
  parameter int unsigned IDX_W    = 7,
  localparam int unsigned ADDR_W  = LOC_W + BANK_W
) (
  input  logic [LOC_W-1:0]  loc,
  input  logic [ADDR_W-1:0] ptr,
  output tgt_e              kind,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned HALF     = 1 << (LOC_W - 1);
  localparam int unsigned SHARED_N = HALF - GPR_BASE;

  logic [ADDR_W-1:0] eff;
  logic [LOC_W-1:0]  off;
  logic [BANK_W-1:0] bnk;

  always_comb begin
    eff  = (loc == '0) ? ptr : {ptr[ADDR_W-1:LOC_W], loc};
    off  = eff[LOC_W-1:0];
    bnk  = eff[ADDR_W-1:LOC_W];
    kind = TGT_NONE;
    idx  = '0;
    if (off[LOC_W-1]) begin
      kind = TGT_GPR;
      idx  = IDX_W'(SHARED_N) + IDX_W'({bnk, off[LOC_W-2:0]});
    end else if (off == '0) begin
      kind = TGT_NULL;
    end else if (off == LOC_W'(STAT_LOC)) begin
      kind = TGT_STAT;
    end else if (off == LOC_W'(PTR_LOC)) begin
      kind = TGT_PTR;
    end else if (off >= LOC_W'(GPR_BASE)) begin
      kind = TGT_GPR;
      idx  = IDX_W'(off - LOC_W'(GPR_BASE));
    end
  end

endmodule

// File: rtl/dmem_gpr_array.sv
module dmem_gpr_array #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 72,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/dmem_status_unit.sv
module dmem_status_unit
  import dmem_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  input  logic          flags_vld,
  input  logic [2:0]    alu_flags,
  output logic [DW-1:0] status_q
);

  logic       wake_q, wake_d;
  logic       page_q, page_d;
  logic [2:0] flg_q,  flg_d;
  logic       sw_en, flg_en;

  always_comb begin
    sw_en  = wr_stb;
    flg_en = wr_stb | flags_vld;
    wake_d = wdata[SB_WAKE];
    page_d = wdata[SB_PAGE];
    flg_d  = flags_vld ? alu_flags : wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      page_q <= 1'b0;
      flg_q  <= '0;
    end else begin
      if (sw_en) begin
        wake_q <= wake_d;
        page_q <= page_d;
      end
      if (flg_en) begin
        flg_q <= flg_d;
      end
    end
  end

  always_comb begin
    status_q          = '0;
    status_q[SB_WAKE] = wake_q;
    status_q[SB_PAGE] = page_q;
    status_q[SB_TO]   = 1'b1;
    status_q[SB_PD]   = 1'b1;
    status_q[2:0]     = flg_q;
  end

endmodule

// File: rtl/dmem_bank_access.sv
module dmem_bank_access
  import dmem_pkg::*;
#(
  parameter int unsigned LOC_W    = 5,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned DW       = 8,
  parameter int unsigned GPR_BASE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] rd_loc,
  input  logic [LOC_W-1:0] wr_loc,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_en,
  input  logic [2:0]       alu_flags,
  input  logic             flags_vld,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    status_q,
  output logic [DW-1:0]    ptr_q
);

  localparam int unsigned ADDR_W = LOC_W + BANK_W;
  localparam int unsigned HALF   = 1 << (LOC_W - 1);
  localparam int unsigned NBANK  = 1 << BANK_W;
  localparam int unsigned DEPTH  = (HALF - GPR_BASE) + NBANK * HALF;
  localparam int unsigned IDX_W  = $clog2(DEPTH);

  logic rst_meta, rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  logic [ADDR_W-1:0] ptr_r, ptr_d;
  logic              ptr_en;
  tgt_e              rkind, wkind;
  logic [IDX_W-1:0]  ridx, widx;
  logic [DW-1:0]     gpr_rd;
  logic              gpr_we, stat_we;

  dmem_addr_resolve #(
    .LOC_W(LOC_W), .BANK_W(BANK_W), .GPR_BASE(GPR_BASE), .IDX_W(IDX_W)
  ) u_rd_res (
    .loc(rd_loc), .ptr(ptr_r), .kind(rkind), .idx(ridx)
  );

  dmem_addr_resolve #(
    .LOC_W(LOC_W), .BANK_W(BANK_W), .GPR_BASE(GPR_BASE), .IDX_W(IDX_W)
  ) u_wr_res (
    .loc(wr_loc), .ptr(ptr_r), .kind(wkind), .idx(widx)
  );

  always_comb begin
    gpr_we  = wr_en && (wkind == TGT_GPR);
    stat_we = wr_en && (wkind == TGT_STAT);
    ptr_en  = wr_en && (wkind == TGT_PTR);
    ptr_d   = wr_data[ADDR_W-1:0];
  end

  dmem_gpr_array #(
    .DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_gpr (
    .clk(clk), .we(gpr_we), .widx(widx), .wdata(wr_data),
    .ridx(ridx), .rdata(gpr_rd)
  );

  dmem_status_unit #(
    .DW(DW)
  ) u_stat (
    .clk(clk), .rst_n(rst_n_sync), .wr_stb(stat_we), .wdata(wr_data),
    .flags_vld(flags_vld), .alu_flags(alu_flags), .status_q(status_q)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ptr_r <= '0;
    end else if (ptr_en) begin
      ptr_r <= ptr_d;
    end
  end

  assign ptr_q = {{(DW-ADDR_W){1'b0}}, ptr_r};

  always_comb begin
    unique case (rkind)
      TGT_STAT: rd_data = status_q;
      TGT_PTR:  rd_data = ptr_q;
      TGT_GPR:  rd_data = gpr_rd;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dmem_bank_access_chk.sv
module dmem_bank_access_chk
  import dmem_pkg::*;
#(
  parameter int unsigned LOC_W = 5,
  parameter int unsigned DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LOC_W-1:0] rd_loc,
  input logic [LOC_W-1:0] wr_loc,
  input logic [DW-1:0]    wr_data,
  input logic             wr_en,
  input logic [2:0]       alu_flags,
  input logic             flags_vld,
  input logic [DW-1:0]    rd_data,
  input logic [DW-1:0]    status_q,
  input logic [DW-1:0]    ptr_q
);

  assert_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_vld |=> status_q[2:0] == $past(alu_flags));

  assert_side_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loc == LOC_W'(STAT_LOC) && flags_vld)
      |=> status_q[SB_WAKE] == $past(wr_data[SB_WAKE]));

  assert_stat_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loc == LOC_W'(STAT_LOC) && !flags_vld)
      |=> (status_q[2:0] == $past(wr_data[2:0])) &&
          (status_q[SB_PAGE] == $past(wr_data[SB_PAGE])));

  assert_ptr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loc == LOC_W'(PTR_LOC))
      |=> ptr_q == {1'b0, $past(wr_data[DW-2:0])});

  assert_null_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_loc == '0 && ptr_q[LOC_W-1:0] == '0) |-> rd_data == '0);

  assert_null_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loc == '0 && ptr_q[LOC_W-1:0] == '0 && !flags_vld)
      |=> $stable(ptr_q) && $stable(status_q));

  assert_unimpl_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_loc == 5'h01 || rd_loc == 5'h02 || rd_loc == 5'h05 ||
     rd_loc == 5'h06 || rd_loc == 5'h07) |-> rd_data == '0);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !flags_vld) |=> $stable(status_q) && $stable(ptr_q));

endmodule

bind dmem_bank_access dmem_bank_access_chk #(.LOC_W(LOC_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .rd_loc(rd_loc), .wr_loc(wr_loc),
  .wr_data(wr_data), .wr_en(wr_en), .alu_flags(alu_flags),
  .flags_vld(flags_vld), .rd_data(rd_data), .status_q(status_q),
  .ptr_q(ptr_q)
);

// File: tb/dmem_bank_access_bench.sv
module dmem_bank_access_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] rd_loc, wr_loc;
  logic [7:0] wr_data;
  logic       wr_en;
  logic [2:0] alu_flags;
  logic       flags_vld;
  logic [7:0] rd_data, status_q, ptr_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  dmem_bank_access u_dmem_bank_access (
    .clk(clk), .rst_n(rst_n), .rd_loc(rd_loc), .wr_loc(wr_loc),
    .wr_data(wr_data), .wr_en(wr_en), .alu_flags(alu_flags),
    .flags_vld(flags_vld), .rd_data(rd_data), .status_q(status_q),
    .ptr_q(ptr_q)
  );

  typedef struct packed {
    logic       we;
    logic [4:0] wl;
    logic [7:0] wd;
    logic       fv;
    logic [2:0] fl;
    logic [4:0] rl;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'h04, 8'h20, 1'b0, 3'b000, 5'h04, 8'h20, 4'd10}, // R10 bank 1
    '{1'b1, 5'h15, 8'hA1, 1'b0, 3'b000, 5'h15, 8'hA1, 4'd2},  // R2
    '{1'b1, 5'h04, 8'h40, 1'b0, 3'b000, 5'h04, 8'h40, 4'd10}, // R10 bank 2
    '{1'b1, 5'h15, 8'hB2, 1'b0, 3'b000, 5'h15, 8'hB2, 4'd2},  // R2
    '{1'b1, 5'h04, 8'h20, 1'b0, 3'b000, 5'h15, 8'hA1, 4'd2},  // R2 bank 1 kept
    '{1'b1, 5'h0A, 8'h5C, 1'b0, 3'b000, 5'h0A, 8'h5C, 4'd3},  // R3
    '{1'b1, 5'h04, 8'h60, 1'b0, 3'b000, 5'h0A, 8'h5C, 4'd3},  // R3 from bank 3
    '{1'b1, 5'h04, 8'h8A, 1'b0, 3'b000, 5'h04, 8'h0A, 4'd10}, // R10 bit 7 drop
    '{1'b0, 5'h00, 8'h00, 1'b0, 3'b000, 5'h00, 8'h5C, 4'd4},  // R4 read
    '{1'b1, 5'h00, 8'h77, 1'b0, 3'b000, 5'h0A, 8'h77, 4'd4},  // R4 write
    '{1'b1, 5'h04, 8'h35, 1'b0, 3'b000, 5'h00, 8'hA1, 4'd4},  // R4 bank 1
    '{1'b1, 5'h04, 8'h40, 1'b0, 3'b000, 5'h00, 8'h00, 4'd5},  // R5 read
    '{1'b1, 5'h00, 8'hFF, 1'b0, 3'b000, 5'h04, 8'h40, 4'd5},  // R5 write
    '{1'b0, 5'h00, 8'h00, 1'b0, 3'b000, 5'h03, 8'h18, 4'd5},  // R5 status
    '{1'b1, 5'h03, 8'hFF, 1'b0, 3'b000, 5'h03, 8'hBF, 4'd8},  // R8 R7
    '{1'b1, 5'h03, 8'h00, 1'b1, 3'b101, 5'h03, 8'h1D, 4'd9},  // R9
    '{1'b0, 5'h00, 8'h00, 1'b1, 3'b010, 5'h03, 8'h1A, 4'd9},  // R9
    '{1'b1, 5'h03, 8'h00, 1'b0, 3'b000, 5'h03, 8'h18, 4'd7},  // R7
    '{1'b1, 5'h06, 8'h99, 1'b0, 3'b000, 5'h06, 8'h00, 4'd6},  // R6
    '{1'b1, 5'h01, 8'h12, 1'b0, 3'b000, 5'h01, 8'h00, 4'd6},  // R6
    '{1'b1, 5'h04, 8'h0A, 1'b0, 3'b000, 5'h0A, 8'h77, 4'd6},  // R6 no spill
    '{1'b1, 5'h04, 8'h43, 1'b0, 3'b000, 5'h00, 8'h18, 4'd3},  // R3 status alias
    '{1'b1, 5'h00, 8'h20, 1'b0, 3'b000, 5'h03, 8'h38, 4'd3},  // R3 indirect status
    '{1'b1, 5'h04, 8'h24, 1'b0, 3'b000, 5'h00, 8'h24, 4'd3},  // R3 ptr alias
    '{1'b1, 5'h00, 8'h05, 1'b0, 3'b000, 5'h04, 8'h05, 4'd3}   // R3 R10 indirect ptr
  };

  task automatic check(input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_loc = '0; wr_data = '0;
    flags_vld = 1'b0; alu_flags = '0; rd_loc = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R1 status in reset", status_q, 8'h18);
    check("R1 ptr in reset", ptr_q, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 status after reset", status_q, 8'h18);
    check("R1 ptr after reset", ptr_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].we; wr_loc = VEC[i].wl; wr_data = VEC[i].wd;
      flags_vld = VEC[i].fv; alu_flags = VEC[i].fl; rd_loc = VEC[i].rl;
      @(posedge clk);
      #5;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
    end

    // R11: read shows old value until the edge
    @(negedge clk);
    idle();
    wr_en = 1'b1; wr_loc = 5'h04; wr_data = 8'h00;
    @(negedge clk);
    wr_loc = 5'h1E; wr_data = 8'h22;
    @(negedge clk);
    wr_data = 8'h33; rd_loc = 5'h1E;
    #5;
    check("R11 before edge", rd_data, 8'h22);
    @(posedge clk);
    #5;
    check("R11 after edge", rd_data, 8'h33);

    // R9: status write bit 5 kept while flags win
    @(negedge clk);
    idle();
    wr_en = 1'b1; wr_loc = 5'h03; wr_data = 8'hA7;
    flags_vld = 1'b1; alu_flags = 3'b000;
    @(posedge clk);
    #5;
    check("R9 flags win, bits 7 and 5 written", status_q, 8'hB8);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #5;
    check("R1 status mid-run reset", status_q, 8'h18);
    check("R1 ptr mid-run reset", ptr_q, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

endmodule